// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave holding six 8-bit configuration registers for a clock-distribution device. The registers drive parallel outputs that control which clock outputs run and which delay path is selected. A host writes them in block-write form: it sends the slave address, a command code, a byte count and then data bytes. The slave acknowledges the command code and the byte count but does not use them. Data always fills the registers from register 0 upward, and the host may stop after any complete byte.

A read starts with the read form of the address. The slave first returns a byte count of 06h and then registers 0 to 5 in order. The host acknowledges each byte, and a non-acknowledge ends the transfer. Both bus lines are sampled in the system clock domain through two-flop synchronisers. The slave pulls SDA low through a separate output-enable. The design targets standard-mode bit rates of 100 kbit/s or slower, where one bus bit lasts many system clock cycles.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 0 is 00h, registers 1, 2 and 3 are FFh, registers 4 and 5 are 00h, and `sda_oe` is low.
- R2: The slave answers only to the 7-bit address 69h, sent MSB first with the R/W bit as LSB (D2h write, D3h read). Any other address gets no acknowledge and leaves the registers unchanged.
- R3: In a write frame, every byte after the address is acknowledged (SDA low in the ninth clock). The first two of these bytes (command code and byte count) change no register.
- R4: Data bytes of a write frame, MSB first, load register 0, then 1, and so on in ascending order.
- R5: A stop after k complete data bytes leaves registers k to 5 at their previous values.
- R6: Data bytes past register 5 are acknowledged and discarded.
- R7: A read frame returns 06h first, then registers 0 to 5, each MSB first, and 00h for any later byte.
- R8: A master non-acknowledge after any read byte ends the transfer. SDA stays released until the next start.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A start condition received in the middle of a frame, before any stop, restarts decoding at the address byte. A new write frame then loads data from register 0 again.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_regs | output | 48 | Register k at bits [8k+7:8k] |

## Verification
The checks assume that SCL and SDA each stay stable for well over the three-cycle synchroniser-and-register latency between changes. They also assume that SDA changes while SCL is high only to form a start or a stop, and that the host never issues a stop while the slave is driving a data bit. The bench's bus tasks keep every line change at least five system clocks away from the SCL edge it relates to. They change data only in the middle of the SCL low phase and finish each read with a non-acknowledge before any stop. Random data, random write lengths from zero to eight bytes, and occasional wrong addresses are then driven within those limits.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_SACK,
    ST_TX,
    ST_MACK
  } bus_state_t;

  // power-up value of register idx
  function automatic logic [7:0] reg_reset(input int idx);
    return (idx >= 1 && idx <= 3) ? 8'hFF : 8'h00;
  endfunction

  // which register a write-frame byte targets; frame bytes 0 and 1 are skipped
  function automatic logic [7:0] data_slot(input logic [7:0] frame_idx);
    return frame_idx - 8'd2;
  endfunction
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_bus_engine.sv
module cfg_bus_engine
  import cfgser_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sda_s,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    ev_start,
  input  logic                    ev_stop,
  input  logic [NUM_REGS*8-1:0]   regs,
  output logic                    sda_oe,
  output logic                    bus_idle,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [7:0]              wr_data
);
  bus_state_t st;
  logic [3:0] bit_cnt;
  logic [7:0] sh;
  logic [7:0] byte_idx;
  logic       addr_ph;
  logic       rd_mode;
  logic [7:0] tx_byte;
  logic [7:0] slot;

  // read byte 0 is the count, byte k is register k-1, past the end 00h
  always_comb begin
    tx_byte = 8'h00;
    if (byte_idx == 8'd0) tx_byte = 8'(NUM_REGS);
    else if (byte_idx <= 8'(NUM_REGS)) tx_byte = regs[8*(int'(byte_idx)-1) +: 8];
  end

  assign slot     = data_slot(byte_idx);
  assign bus_idle = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      byte_idx <= '0;
      addr_ph  <= 1'b0;
      rd_mode  <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        st       <= ST_RX;
        bit_cnt  <= '0;
        addr_ph  <= 1'b1;
        byte_idx <= '0;
        sda_oe   <= 1'b0;
      end else if (ev_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              sh      <= {sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (addr_ph) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rd_mode <= sh[0];
                  addr_ph <= 1'b0;
                  sda_oe  <= 1'b1;
                  st      <= ST_SACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                if (byte_idx >= 8'd2 && slot < 8'(NUM_REGS)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= slot[IDX_W-1:0];
                  wr_data <= sh;
                end
                if (byte_idx != 8'hFF) byte_idx <= byte_idx + 8'd1;
                sda_oe <= 1'b1;
                st     <= ST_SACK;
              end
            end
          end
          ST_SACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                sh      <= tx_byte;
                sda_oe  <= ~tx_byte[7];
                bit_cnt <= 4'd1;
                st      <= ST_TX;
              end else begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                st      <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
                if (byte_idx != 8'hFF) byte_idx <= byte_idx + 8'd1;
              end else begin
                sda_oe  <= ~sh[6];
                sh      <= {sh[6:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
            end else if (scl_fall) begin
              sh      <= tx_byte;
              sda_oe  <= ~tx_byte[7];
              bit_cnt <= 4'd1;
              st      <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfgser_pkg::*;
#(
  parameter int  NUM_REGS = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[8*g +: 8] <= reg_reset(g);
      else if (wr_en && wr_idx == IDX_W'(g)) regs[8*g +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  logic scl_sync, sda_sync, scl_rise, scl_fall, ev_start, ev_stop;
  logic bus_idle, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  cfg_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  cfg_bus_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_sync), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .regs(cfg_regs), .sda_oe(sda_oe), .bus_idle(bus_idle),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs(cfg_regs)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int  NUM_REGS = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_sync,
  input logic                  sda_oe,
  input logic                  bus_idle,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] cfg_regs
);
  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  // R6
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  // R9
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);

  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_regs));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .sda_oe(sda_oe),
  .bus_idle(bus_idle), .wr_en(wr_en), .wr_idx(wr_idx), .cfg_regs(cfg_regs)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int NR = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_lo = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] cfg_regs;
  wire  sda_line = !(m_lo | sda_oe);

  int n_chk = 0, n_fail = 0, r9_bad = 0;
  bit done = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_reg [NR];
  logic [7:0] wbuf [10];

  always #2 clk = ~clk;

  cfg_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  // R9 monitor: drive change seen while SCL high
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != prev_oe) r9_bad++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] pwr_val(input int i);
    return (i == 1 || i == 2 || i == 3) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [7:0] read_exp(input int k);
    if (k == 0) return 8'h06;
    if (k <= NR) return exp_reg[k-1];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_lo = 1'b0; wt(5); scl = 1'b1; wt(10);
    m_lo = 1'b1; wt(10); scl = 1'b0;
  endtask

  task automatic bus_stop;
    wt(5); m_lo = 1'b1; wt(5); scl = 1'b1; wt(10);
    m_lo = 1'b0; wt(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wt(5); m_lo = ~b[i]; wt(5); scl = 1'b1; wt(10); scl = 1'b0;
    end
    wt(5); m_lo = 1'b0; wt(5); scl = 1'b1; wt(5);
    acked = !sda_line; wt(5); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(5); m_lo = 1'b0; wt(5); scl = 1'b1; wt(5);
      b[i] = sda_line; wt(5); scl = 1'b0;
    end
    wt(5); m_lo = ack; wt(5); scl = 1'b1; wt(10); scl = 1'b0;
    wt(5); m_lo = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++)
      chk(cfg_regs[8*i +: 8] == exp_reg[i], tag, cfg_regs[8*i +: 8], exp_reg[i]);
  endtask

  // write frame: address D2h, command, count, n data bytes from wbuf
  task automatic write_frame(input int n);
    bit a;
    bus_start();
    send_byte(8'hD2, a);  chk(a, "R2 write address ack", a, 1);
    send_byte(8'hA5, a);  chk(a, "R3 command ack", a, 1);
    send_byte(8'h3C, a);  chk(a, "R3 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(a, i < NR ? "R4 data ack" : "R6 extra data ack", a, 1);
      if (i < NR) exp_reg[i] = wbuf[i];
    end
    bus_stop();
  endtask

  // read n bytes, nack on the last
  task automatic read_frame(input int n);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, b);
      chk(b == read_exp(k), "R7 read byte", b, read_exp(k));
    end
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NR; i++) exp_reg[i] = pwr_val(i);
    wt(5); rst_n = 1'b1; wt(10);
    // R1
    check_regs("R1 reset value");
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

    // R3 command/count only: no register change
    write_frame(0);
    check_regs("R3 command and count ignored");

    // R4 full write
    for (int i = 0; i < NR; i++) wbuf[i] = 8'h11 * (i + 1);
    write_frame(NR);
    check_regs("R4 sequential load");

    // R5 partial write of two bytes
    wbuf[0] = 8'hC3; wbuf[1] = 8'h5A;
    write_frame(2);
    check_regs("R5 partial write keeps upper");

    // R6 overflow write of eight bytes
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hE0 + 8'(i);
    write_frame(8);
    check_regs("R6 overflow discarded");

    // R2 wrong address
    bus_start();
    send_byte(8'hA2, a); chk(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h77, a);
    bus_stop();
    check_regs("R2 foreign address no effect");

    // R7 read past end
    read_frame(9);

    // R8 nack after second byte, then bus traffic with SDA high
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b); chk(b == 8'h06, "R8 count before nack", b, 8'h06);
    recv_byte(1'b0, b); chk(b == exp_reg[0], "R8 byte before nack", b, exp_reg[0]);
    for (int i = 0; i < 9; i++) begin
      wt(10); scl = 1'b1; wt(10);
      chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
      scl = 1'b0;
    end
    bus_stop();

    // R10 repeated start mid-write, then a fresh write
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h01, a); send_byte(8'h06, a);
    send_byte(8'h9D, a); exp_reg[0] = 8'h9D;
    wt(5); m_lo = 1'b0;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R10 address after restart", a, 1);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h4B, a); exp_reg[0] = 8'h4B;
    bus_stop();
    check_regs("R10 restart reloads register 0");

    // random frames
    for (int it = 0; it < 12; it++) begin
      int n = $urandom_range(0, 8);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        bus_start();
        send_byte(8'hD0 | 8'($urandom_range(0, 1) * 8), a);
        chk(!a, "R2 random foreign address", a, 0);
        bus_stop();
      end else begin
        write_frame(n);
      end
      check_regs("R5 random write");
      read_frame(NR + 1);
    end

    chk(r9_bad == 0, "R9 drive changes while SCL high", r9_bad, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule